// File: doc/BRIEF.md
# Prioritized DMA Request Arbiter

This block sits between the peripherals and the single bus master of a DMA engine. Each of eight channels is bound to one of sixteen peripheral request lines. A peripheral raises either a single-transfer request or a burst request on its line. A channel can also be marked memory-to-memory, which makes it pending whenever it is enabled, with no request line involved. When the arbiter is idle it picks the lowest-numbered pending channel under a fixed hardware priority. It then publishes that channel, whether the grant is a burst, and how many beats remain.

The grant holds until the data engine reports the last beat through `xfer_done`. After that the arbiter spends one cycle in a release state and sends a one-cycle clear pulse back on the served request line, then returns to idle and arbitrates again.

The controller has three states, all of them enumerated in the package:
- **IDLE**: no grant. On a clock edge with a pending channel it takes the transition *arbitrate* to BUSY and latches the winner.
- **BUSY**: the grant is shown. Each `xfer_done` takes the transition *beat*, which counts one beat down. The final beat takes the transition *finish* to RELEASE.
- **RELEASE**: the clear pulse is sent, unless the channel is memory-to-memory. The transition *retire* then goes back to IDLE unconditionally.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held and after it is released, with no pending channel, `grant_valid` is 0 and `preq_clear` is all zeros.
- R2: Channel c is pending when `ch_enable[c]` is 1 and its bound line has its single or burst request set. The bound line is `ch_req_sel[4c+3:4c]`. A disabled channel produces no grant, and neither does a request on a line bound to no channel.
- R3: Among the pending channels, the lowest-numbered one is granted. Channel 0 has the highest priority and channel 7 the lowest.
- R4: A grant is a burst (`grant_burst`=1, starting at `burst_len` beats) when the bound line's burst request is set. A burst_len of 0 counts as 1 beat. When only the single request is set, the grant is a single transfer (`grant_burst`=0, 1 beat). When both requests are set on one line, the burst wins.
- R5: `grant_valid` rises one cycle after the clock edge at which IDLE sees a pending channel. `grant_ch` and `grant_burst` stay constant until the final beat, and a higher-priority request arriving mid-transaction does not preempt the grant.
- R6: In the cycle after the edge that takes the final `xfer_done`, `preq_clear` is one-hot on the served line for exactly one cycle, and `grant_valid` is 0. The next cycle is IDLE, and a new grant can follow one cycle after that.
- R7: A channel with `ch_mem2mem` set is pending whenever it is enabled, whatever its request line carries. It is served as a burst, and its release raises no clear pulse.
- R8: `grant_beats` shows the beats that remain. It drops by one on each edge that takes `xfer_done` during a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | 8 | Per-channel enable |
| ch_mem2mem | input | 8 | Per-channel memory-to-memory flag (no request line needed) |
| ch_req_sel | input | 32 | Request line bound to each channel, 4 bits per channel |
| burst_len | input | 8 | Beats in a burst grant (0 treated as 1) |
| preq_single | input | 16 | Single-transfer request per peripheral line |
| preq_burst | input | 16 | Burst request per peripheral line |
| xfer_done | input | 1 | One beat of the granted transaction finished |
| grant_valid | output | 1 | A channel holds the bus master |
| grant_ch | output | 3 | Granted channel index |
| grant_burst | output | 1 | Grant is a burst (1) or a single transfer (0) |
| grant_beats | output | 8 | Beats remaining in the current grant |
| preq_clear | output | 16 | One-cycle clear pulse on the served request line |

## Verification
A grant is due one cycle after the edge at which a pending request is first seen in IDLE. The clear pulse is due one cycle after the edge that takes the last beat, and the next grant can come no earlier than two cycles after that pulse. The bench drives every input just after a falling edge and samples just before the next one, so each expected value is read exactly the number of rising edges after its stimulus that these delays give. While the pulse is visible the bench drops the served request, so the idle cycle that follows does not re-grant a request that has already been served.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_RELEASE = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dreq_pend.sv
module dreq_pend #(
    parameter int NUM_CH  = 8,
    parameter int NUM_REQ = 16,
    localparam int REQ_W  = $clog2(NUM_REQ)
) (
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH-1:0]       ch_mem2mem,
    input  logic [NUM_CH*REQ_W-1:0] ch_req_sel,
    input  logic [NUM_REQ-1:0]      preq_single,
    input  logic [NUM_REQ-1:0]      preq_burst,
    output logic [NUM_CH-1:0]       ch_pend,
    output logic [NUM_CH-1:0]       ch_is_burst
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [REQ_W-1:0] sel;
        logic             line_s;
        logic             line_b;
        assign sel    = ch_req_sel[c*REQ_W +: REQ_W];
        assign line_s = preq_single[sel];
        assign line_b = preq_burst[sel];
        // Pending from the bound line, or unconditionally for memory-to-memory.
        assign ch_pend[c]     = ch_enable[c] & (ch_mem2mem[c] | line_s | line_b);
        // A burst request outranks a single request on the same line.
        assign ch_is_burst[c] = ch_mem2mem[c] | line_b;
    end
endmodule

// File: rtl/dreq_prio.sv
module dreq_prio #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] ch_pend,
    output logic              win_valid,
    output logic [CH_W-1:0]   win_ch
);
    logic [NUM_CH-1:0] below_win;

    always_comb begin
        win_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_pend[i]) begin
                win_ch = CH_W'(i);
            end
        end
    end

    assign win_valid = |ch_pend;

    // Channels with a lower index than the winner must all be idle.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            below_win[i] = ch_pend[i] && (CH_W'(i) < win_ch);
        end
        if (win_valid) begin
            AST_PRIO_LOWEST_WINS: assert (below_win == '0 && ch_pend[win_ch]); // R3
        end
    end
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_REQ = 16,
    parameter int LEN_W   = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int REQ_W  = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [CH_W-1:0]    win_ch,
    input  logic               win_burst,
    input  logic               win_m2m,
    input  logic [REQ_W-1:0]   win_line,
    input  logic [LEN_W-1:0]   burst_len,
    input  logic               xfer_done,
    output logic               grant_valid,
    output logic [CH_W-1:0]    grant_ch,
    output logic               grant_burst,
    output logic [LEN_W-1:0]   grant_beats,
    output logic [NUM_REQ-1:0] preq_clear
);
    arb_state_e       state_q, state_d;
    logic [CH_W-1:0]  ch_q;
    logic [REQ_W-1:0] line_q;
    logic             burst_q;
    logic             m2m_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] first_beats;
    logic             last_beat;

    assign first_beats = !win_burst       ? LEN_W'(1) :
                         (burst_len == '0) ? LEN_W'(1) : burst_len;
    assign last_beat   = xfer_done && (left_q == LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win_valid) state_d = ST_BUSY;
            ST_BUSY:    if (last_beat) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Grant context, latched at arbitration and counted down per beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            line_q  <= '0;
            burst_q <= 1'b0;
            m2m_q   <= 1'b0;
            left_q  <= '0;
        end else if (state_q == ST_IDLE && win_valid) begin
            ch_q    <= win_ch;
            line_q  <= win_line;
            burst_q <= win_burst;
            m2m_q   <= win_m2m;
            left_q  <= first_beats;
        end else if (state_q == ST_BUSY && xfer_done) begin
            left_q  <= left_q - LEN_W'(1);
        end
    end

    // Outputs
    always_comb begin
        grant_valid = 1'b0;
        preq_clear  = '0;
        grant_ch    = ch_q;
        grant_burst = burst_q;
        grant_beats = left_q;
        unique case (state_q)
            ST_IDLE:    ;
            ST_BUSY:    grant_valid = 1'b1;
            ST_RELEASE: if (!m2m_q) preq_clear[line_q] = 1'b1;
            default:    ;
        endcase
    end

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(grant_valid)) |-> ($stable(grant_ch) && $stable(grant_burst))); // R5
    AST_BEATS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_beats != '0)); // R4
    AST_BEAT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done && grant_beats > LEN_W'(1))
        |=> (grant_valid && grant_beats == $past(grant_beats) - LEN_W'(1))); // R8
    AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(preq_clear)); // R6
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|preq_clear) |=> (preq_clear == '0)); // R6
    AST_NO_GRANT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|preq_clear) |-> !grant_valid); // R6
    AST_LAST_BEAT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done && grant_beats == LEN_W'(1)) |=> !grant_valid); // R6
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NUM_CH  = 8,
    parameter int NUM_REQ = 16,
    parameter int LEN_W   = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int REQ_W  = $clog2(NUM_REQ)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH-1:0]       ch_mem2mem,
    input  logic [NUM_CH*REQ_W-1:0] ch_req_sel,
    input  logic [LEN_W-1:0]        burst_len,
    input  logic [NUM_REQ-1:0]      preq_single,
    input  logic [NUM_REQ-1:0]      preq_burst,
    input  logic                    xfer_done,
    output logic                    grant_valid,
    output logic [CH_W-1:0]         grant_ch,
    output logic                    grant_burst,
    output logic [LEN_W-1:0]        grant_beats,
    output logic [NUM_REQ-1:0]      preq_clear
);
    logic [NUM_CH-1:0] ch_pend;
    logic [NUM_CH-1:0] ch_is_burst;
    logic              win_valid;
    logic [CH_W-1:0]   win_ch;
    logic [REQ_W-1:0]  win_line;

    dreq_pend #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) u_pend (
        .ch_enable   (ch_enable),
        .ch_mem2mem  (ch_mem2mem),
        .ch_req_sel  (ch_req_sel),
        .preq_single (preq_single),
        .preq_burst  (preq_burst),
        .ch_pend     (ch_pend),
        .ch_is_burst (ch_is_burst)
    );

    dreq_prio #(.NUM_CH(NUM_CH)) u_prio (
        .ch_pend   (ch_pend),
        .win_valid (win_valid),
        .win_ch    (win_ch)
    );

    assign win_line = ch_req_sel[win_ch*REQ_W +: REQ_W];

    dreq_fsm #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ), .LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid   (win_valid),
        .win_ch      (win_ch),
        .win_burst   (ch_is_burst[win_ch]),
        .win_m2m     (ch_mem2mem[win_ch]),
        .win_line    (win_line),
        .burst_len   (burst_len),
        .xfer_done   (xfer_done),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch),
        .grant_burst (grant_burst),
        .grant_beats (grant_beats),
        .preq_clear  (preq_clear)
    );

    AST_GRANT_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(win_valid)); // R2
endmodule

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ch_enable = '0;
    logic [7:0]  ch_mem2mem = '0;
    logic [31:0] ch_req_sel;
    logic [7:0]  burst_len = 8'd3;
    logic [15:0] preq_single = '0;
    logic [15:0] preq_burst = '0;
    logic        xfer_done = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_ch;
    logic        grant_burst;
    logic [7:0]  grant_beats;
    logic [15:0] preq_clear;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Channel c is bound to line 2c; odd lines are bound to nothing.
    initial begin
        for (int c = 0; c < 8; c++) ch_req_sel[c*4 +: 4] = 4'(2*c);
    end

    dma_req_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_mem2mem(ch_mem2mem),
        .ch_req_sel(ch_req_sel), .burst_len(burst_len), .preq_single(preq_single),
        .preq_burst(preq_burst), .xfer_done(xfer_done), .grant_valid(grant_valid),
        .grant_ch(grant_ch), .grant_burst(grant_burst), .grant_beats(grant_beats),
        .preq_clear(preq_clear)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] single;
        logic [15:0] burst;
        logic [7:0]  en;
        logic        exp_valid;
        logic [2:0]  exp_ch;
        logic        exp_burst;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0040, 16'h0000, 8'hFF, 1'b1, 3'd3, 1'b0},  // R4 single on ch3
        '{16'h0000, 16'h0400, 8'hFF, 1'b1, 3'd5, 1'b1},  // R4 burst on ch5
        '{16'h0010, 16'h1000, 8'hFF, 1'b1, 3'd2, 1'b0},  // R3 ch2 beats ch6
        '{16'h0004, 16'h0004, 8'hFF, 1'b1, 3'd1, 1'b1},  // R4 both on one line
        '{16'h0001, 16'h4000, 8'hFE, 1'b1, 3'd7, 1'b1},  // R2 ch0 disabled
        '{16'h0008, 16'h0000, 8'hFF, 1'b0, 3'd0, 1'b0},  // R2 unbound line
        '{16'h5555, 16'h0000, 8'hFF, 1'b1, 3'd0, 1'b0},  // R3 all pending
        '{16'h4100, 16'h0000, 8'h00, 1'b0, 3'd0, 1'b0}   // R2 all disabled
    };

    task automatic finish_beats(input int n);
        xfer_done = 1'b1;
        repeat (n) @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        check("R1", "grant_valid in reset", int'(grant_valid), 0);
        check("R1", "preq_clear in reset", int'(preq_clear), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "grant_valid idle", int'(grant_valid), 0);
        check("R1", "preq_clear idle", int'(preq_clear), 0);

        // Table walk, burst_len = 3
        for (int v = 0; v < NV; v++) begin
            preq_single = VECS[v].single;
            preq_burst  = VECS[v].burst;
            ch_enable   = VECS[v].en;
            @(negedge clk);
            check("R5", $sformatf("vec%0d grant_valid", v), int'(grant_valid), int'(VECS[v].exp_valid));
            if (VECS[v].exp_valid) begin
                check("R3", $sformatf("vec%0d grant_ch", v), int'(grant_ch), int'(VECS[v].exp_ch));
                check("R4", $sformatf("vec%0d grant_burst", v), int'(grant_burst), int'(VECS[v].exp_burst));
                check("R4", $sformatf("vec%0d grant_beats", v), int'(grant_beats), VECS[v].exp_burst ? 3 : 1);
                finish_beats(VECS[v].exp_burst ? 3 : 1);
                check("R6", $sformatf("vec%0d preq_clear", v), int'(preq_clear), 1 << (2 * VECS[v].exp_ch));
                check("R6", $sformatf("vec%0d grant low on clear", v), int'(grant_valid), 0);
                preq_single = '0;
                preq_burst  = '0;
                @(negedge clk);
                check("R6", $sformatf("vec%0d clear one cycle", v), int'(preq_clear), 0);
            end else begin
                @(negedge clk);
                check("R2", $sformatf("vec%0d still no grant", v), int'(grant_valid), 0);
                preq_single = '0;
                preq_burst  = '0;
            end
            @(negedge clk);
        end

        // No preemption mid-burst; countdown of beats
        ch_enable  = 8'hFF;
        burst_len  = 8'd4;
        preq_burst = 16'h0400;
        @(negedge clk);
        check("R5", "preempt base grant ch", int'(grant_ch), 5);
        finish_beats(2);
        check("R8", "beats after two", int'(grant_beats), 2);
        preq_single = 16'h0001;
        @(negedge clk);
        check("R5", "no preempt ch", int'(grant_ch), 5);
        check("R5", "no preempt valid", int'(grant_valid), 1);
        finish_beats(2);
        check("R6", "clear on line 10 only", int'(preq_clear), 16'h0400);
        preq_burst = '0;
        @(negedge clk);
        check("R6", "idle after release", int'(grant_valid), 0);
        @(negedge clk);
        check("R6", "next grant ch0", int'(grant_ch), 0);
        check("R4", "next grant single", int'(grant_burst), 0);
        finish_beats(1);
        check("R6", "clear on line 0", int'(preq_clear), 16'h0001);
        preq_single = '0;
        @(negedge clk);
        @(negedge clk);

        // burst_len of zero counts as one beat
        burst_len  = 8'd0;
        preq_burst = 16'h0100;
        @(negedge clk);
        check("R4", "zero len beats", int'(grant_beats), 1);
        finish_beats(1);
        check("R4", "zero len releases after one", int'(preq_clear), 16'h0100);
        preq_burst = '0;
        @(negedge clk);
        @(negedge clk);

        // Memory-to-memory channel with no request lines
        burst_len  = 8'd2;
        ch_enable  = 8'h08;
        ch_mem2mem = 8'h08;
        @(negedge clk);
        check("R7", "m2m grant", int'(grant_valid), 1);
        check("R7", "m2m ch", int'(grant_ch), 3);
        check("R7", "m2m burst", int'(grant_burst), 1);
        finish_beats(2);
        check("R7", "m2m no clear", int'(preq_clear), 0);
        check("R7", "m2m released", int'(grant_valid), 0);
        ch_enable  = '0;
        ch_mem2mem = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "quiet at end", int'(grant_valid), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule